// File: doc/BRIEF.md
# Serial-Loaded Octal Low-Side Switch Controller

This block is the digital heart of an eight-channel low-side switch. A host sends channel on/off bits over a serial clock and data pair into a shift register. A strobe copies the register into an output buffer: the buffer follows the register while the strobe is high and holds its value once the strobe falls. The last shift stage is driven out as a serial output, so several such parts, or parts of other lengths, can sit in one chain and all update on a single shared strobe.

Each channel has its own over-current input from the analog sense circuit. An over-current event shuts down only that channel and keeps it off until a later strobe. It also sets a shared active-low fault flag, which stays low until the strobe. An active-low enable turns off every channel, and so does an over-temperature input, which does not touch the fault flag. An asynchronous power-on reset clears all state. Every asynchronous input is brought into the block's clock domain through a synchronizer chain, and all logic runs on that clock.

Top module: `octal_switch_ctl`

## Requirements
- R1: A rising edge of the serial clock shifts the serial data bit into the first stage of the N_CH-stage shift register, and every other stage moves one place towards the output.
- R2: The serial data output carries the last shift stage. After N_CH bits have been shifted, it presents the first of them, and each further serial clock edge brings out the next bit in order.
- R3: While the strobe is high the output buffer follows the shift register. While the strobe is low the buffer holds its value, even when new bits are shifted in.
- R4: Buffer bit value 1 turns a channel on and 0 turns it off. The first bit shifted in controls channel 1 (drive bit 0) and the N_CH-th bit controls channel N_CH (drive bit N_CH-1).
- R5: While the enable input is high, all drive outputs are 0 whatever the buffer holds. While it is low, the drives follow the buffer.
- R6: An over-current input on one channel turns that channel's drive off. All other channels keep their state.
- R7: A channel that has been shut down for over-current stays off after its over-current input is released. It comes on again only after a strobe with the over-current input inactive.
- R8: The fault flag (active low) goes low on any over-current event. It stays low until a strobe with no over-current input active.
- R9: While the over-temperature input is high, all drives are 0 and the fault flag does not change. When the input falls, the drives return to the buffer contents without a strobe.
- R10: Power-on reset clears the shift register, the buffer, the channel latches and the fault latch. During and after reset all drives are 0, the fault flag is high and the serial output is 0.
- R11: Setting a channel latch or the fault latch wins over clearing it. An over-current input that is still active during a strobe keeps the channel off and the flag low, with no drive pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples all serial and status inputs |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Last shift stage, for daisy-chaining |
| load_stb | input | 1 | Strobe: buffer transparent while high, holds while low |
| en_n | input | 1 | Output enable, active low |
| oc_det | input | N_CH | Per-channel over-current detect flags |
| ot_det | input | 1 | Over-temperature shutdown flag |
| drive | output | N_CH | Gate-drive enables, bit i drives channel i+1 |
| fault_n | output | 1 | Latched over-current fault flag, active low |

## Verification
The bench builds the block with eight channels and a two-stage synchronizer. Every input is held stable longer than the full path from synchronizer to drive flop, so each check reflects the settled cycle behaviour at the chosen depth. Eight channels let walking, sparse and full patterns test the bit-order mapping, and let the serial output test follow a whole byte through the register. The over-current cases fault a middle channel next to healthy neighbours. They also hold the fault across a strobe, which exercises the rule that set wins over clear.

// File: rtl/outctl_pkg.sv
package outctl_pkg;

  // Positions of the single-bit control inputs inside the synchronizer bus.
  typedef enum int unsigned {
    CTL_SCK = 0,
    CTL_SDI = 1,
    CTL_STB = 2,
    CTL_EN  = 3,
    CTL_OT  = 4
  } ctl_idx_e;

  localparam int unsigned CTL_W = 5;

  // Buffer bit i (channel i+1) comes from shift stage N-1-i, i.e. the
  // earliest-shifted bit lands on the lowest channel.
  function automatic int unsigned stage_of_channel(input int unsigned n,
                                                   input int unsigned ch);
    return n - 1 - ch;
  endfunction

endpackage

// File: rtl/outctl_rst_sync.sv
module outctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/outctl_sync.sv
module outctl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d;
      end else begin : g_rest
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/outctl_shift.sv
module outctl_shift
  import outctl_pkg::*;
#(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_s,
  input  logic            sdi_s,
  input  logic            stb_s,
  output logic [N_CH-1:0] buf_q,
  output logic            sdo
);

  logic            sck_prev_q;
  logic            shift_en;
  logic [N_CH-1:0] sr_q;
  logic [N_CH-1:0] sr_d;
  logic [N_CH-1:0] buf_d;
  logic [N_CH-1:0] sr_mapped;

  assign shift_en = sck_s & ~sck_prev_q;

  generate
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_map
      assign sr_mapped[ch] = sr_q[stage_of_channel(N_CH, ch)];
    end
  endgenerate

  always_comb begin
    sr_d  = sr_q;
    buf_d = buf_q;
    if (shift_en) begin
      sr_d = {sr_q[N_CH-2:0], sdi_s};
    end
    if (stb_s) begin
      buf_d = sr_mapped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      sr_q       <= '0;
      buf_q      <= '0;
    end else begin
      sck_prev_q <= sck_s;
      sr_q       <= sr_d;
      buf_q      <= buf_d;
    end
  end

  assign sdo = sr_q[N_CH-1];

endmodule

// File: rtl/outctl_chan.sv
module outctl_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_s,
  input  logic stb_s,
  input  logic buf_bit,
  input  logic gate_ok,
  output logic trip_q,
  output logic drive_q
);

  logic trip_d;
  logic drive_d;

  always_comb begin
    // set wins over the strobe clear
    trip_d  = oc_s | (trip_q & ~stb_s);
    drive_d = buf_bit & gate_ok & ~oc_s & ~trip_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      trip_q  <= trip_d;
      drive_q <= drive_d;
    end
  end

endmodule

// File: rtl/outctl_fault.sv
module outctl_fault #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] oc_s,
  input  logic            stb_s,
  output logic            fault_n
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = (|oc_s) | (flag_q & ~stb_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign fault_n = ~flag_q;

endmodule

// File: rtl/octal_switch_ctl.sv
module octal_switch_ctl
  import outctl_pkg::*;
#(
  parameter int unsigned N_CH        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_clk,
  input  logic            ser_din,
  output logic            ser_dout,
  input  logic            load_stb,
  input  logic            en_n,
  input  logic [N_CH-1:0] oc_det,
  input  logic            ot_det,
  output logic [N_CH-1:0] drive,
  output logic            fault_n
);

  localparam int unsigned RST_STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic             rst_sync_n;
  logic [CTL_W-1:0] ctl_raw;
  logic [CTL_W-1:0] ctl_s;
  logic [N_CH-1:0]  oc_s;
  logic             sck_s;
  logic             sdi_s;
  logic             stb_s;
  logic             en_n_s;
  logic             ot_s;
  logic             gate_ok;
  logic [N_CH-1:0]  buf_q;
  logic [N_CH-1:0]  trip_q;

  outctl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ctl_raw          = '0;
    ctl_raw[CTL_SCK] = ser_clk;
    ctl_raw[CTL_SDI] = ser_din;
    ctl_raw[CTL_STB] = load_stb;
    ctl_raw[CTL_EN]  = en_n;
    ctl_raw[CTL_OT]  = ot_det;
  end

  outctl_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (ctl_raw),
    .q     (ctl_s)
  );

  outctl_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_oc_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (oc_det),
    .q     (oc_s)
  );

  assign sck_s   = ctl_s[CTL_SCK];
  assign sdi_s   = ctl_s[CTL_SDI];
  assign stb_s   = ctl_s[CTL_STB];
  assign en_n_s  = ctl_s[CTL_EN];
  assign ot_s    = ctl_s[CTL_OT];
  assign gate_ok = ~en_n_s & ~ot_s;

  outctl_shift #(.N_CH(N_CH)) u_shift (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .sck_s (sck_s),
    .sdi_s (sdi_s),
    .stb_s (stb_s),
    .buf_q (buf_q),
    .sdo   (ser_dout)
  );

  generate
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
      outctl_chan u_chan (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .oc_s    (oc_s[ch]),
        .stb_s   (stb_s),
        .buf_bit (buf_q[ch]),
        .gate_ok (gate_ok),
        .trip_q  (trip_q[ch]),
        .drive_q (drive[ch])
      );
    end
  endgenerate

  outctl_fault #(.N_CH(N_CH)) u_fault (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .oc_s    (oc_s),
    .stb_s   (stb_s),
    .fault_n (fault_n)
  );

endmodule

// File: rtl/outctl_checker.sv
module outctl_checker #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stb_s,
  input logic            en_n_s,
  input logic            ot_s,
  input logic [N_CH-1:0] oc_s,
  input logic [N_CH-1:0] buf_q,
  input logic [N_CH-1:0] drive,
  input logic            fault_n
);

  p_buf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_s |=> $stable(buf_q));

  p_drive_from_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive & ~$past(buf_q)) == '0);

  p_enable_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_s |=> drive == '0);

  p_oc_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_s != '0) |=> (drive & $past(oc_s)) == '0);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_s != '0) |=> !fault_n);

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !stb_s) |=> !fault_n);

  p_thermal_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ot_s |=> drive == '0);

  p_thermal_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_n && oc_s == '0) |=> fault_n);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_s && oc_s != '0) |=> !fault_n);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r10: assert (drive == '0 && fault_n);
    end
  end

endmodule

bind octal_switch_ctl outctl_checker #(.N_CH(N_CH)) u_outctl_checker (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .stb_s   (stb_s),
  .en_n_s  (en_n_s),
  .ot_s    (ot_s),
  .oc_s    (oc_s),
  .buf_q   (buf_q),
  .drive   (drive),
  .fault_n (fault_n)
);

// File: tb/octal_switch_ctl_test.sv
module octal_switch_ctl_test;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_CH       = 8;
  localparam int unsigned SYNC       = 2;
  localparam int unsigned SETTLE     = 8;

  typedef struct packed {
    logic [7:0] pat;
    logic       en_n;
    logic       ot;
    logic [7:0] exp;
  } vec_t;

  localparam int unsigned NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{8'h01, 1'b0, 1'b0, 8'h01},
    '{8'h80, 1'b0, 1'b0, 8'h80},
    '{8'hA5, 1'b0, 1'b0, 8'hA5},
    '{8'hFF, 1'b1, 1'b0, 8'h00},
    '{8'h3C, 1'b0, 1'b1, 8'h00},
    '{8'h5A, 1'b0, 1'b0, 8'h5A},
    '{8'h00, 1'b0, 1'b0, 8'h00}
  };

  logic            clk;
  logic            rst_n;
  logic            ser_clk;
  logic            ser_din;
  logic            ser_dout;
  logic            load_stb;
  logic            en_n;
  logic [N_CH-1:0] oc_det;
  logic            ot_det;
  logic [N_CH-1:0] drive;
  logic            fault_n;

  int checks;
  int errors;
  bit done;

  octal_switch_ctl #(.N_CH(N_CH), .SYNC_STAGES(SYNC)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_din  (ser_din),
    .ser_dout (ser_dout),
    .load_stb (load_stb),
    .en_n     (en_n),
    .oc_det   (oc_det),
    .ot_det   (ot_det),
    .drive    (drive),
    .fault_n  (fault_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick(input int unsigned n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_din = b;
    tick(SETTLE);
    ser_clk = 1'b1;
    tick(SETTLE);
    ser_clk = 1'b0;
    tick(SETTLE);
  endtask

  task automatic shift_byte(input logic [7:0] p);
    for (int i = 0; i < 8; i++) shift_bit(p[i]);
  endtask

  task automatic strobe();
    load_stb = 1'b1;
    tick(SETTLE);
    load_stb = 1'b0;
    tick(SETTLE);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    tick(200000 - 100);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    ser_clk = 1'b0;
    ser_din = 1'b0;
    load_stb = 1'b0;
    en_n = 1'b0;
    oc_det = '0;
    ot_det = 1'b0;
    tick(4);
    // R10: reset state
    check("R10 drive in reset", drive, 0);
    check("R10 fault_n in reset", fault_n, 1);
    check("R10 sdo in reset", ser_dout, 0);
    rst_n = 1'b1;
    tick(SETTLE);

    // R1 R4 R5 R9: table of patterns
    for (int v = 0; v < NVEC; v++) begin
      en_n = 1'b0;
      ot_det = 1'b0;
      tick(SETTLE);
      shift_byte(VECS[v].pat);
      strobe();
      en_n = VECS[v].en_n;
      ot_det = VECS[v].ot;
      tick(SETTLE);
      check("R4 R5 R9 table drive", drive, VECS[v].exp);
      check("R9 table fault_n", fault_n, 1);
    end
    en_n = 1'b0;
    ot_det = 1'b0;
    tick(SETTLE);
    // R9: drive returns without strobe after over-temperature
    check("R9 recovery", drive, 8'h00);

    // R2: serial output walks out the earlier byte
    shift_byte(8'hC6);
    for (int i = 0; i < 8; i++) begin
      check("R2 sdo order", ser_dout, (8'hC6 >> i) & 1);
      shift_bit(1'b0);
    end
    check("R1 sdo after zero fill", ser_dout, 0);

    // R3: transparent while high, hold while low
    load_stb = 1'b1;
    tick(SETTLE);
    shift_byte(8'h96);
    check("R3 transparent", drive, 8'h96);
    load_stb = 1'b0;
    tick(SETTLE);
    shift_byte(8'h0F);
    check("R3 hold", drive, 8'h96);

    // R6 R7 R8: over-current on channel 3
    shift_byte(8'hFF);
    strobe();
    check("R4 all on", drive, 8'hFF);
    oc_det = 8'h04;
    tick(SETTLE);
    check("R6 only channel 3 off", drive, 8'hFB);
    check("R8 flag low", fault_n, 0);
    oc_det = '0;
    tick(SETTLE);
    check("R7 stays off", drive, 8'hFB);
    check("R8 flag held", fault_n, 0);
    strobe();
    check("R7 back on after strobe", drive, 8'hFF);
    check("R8 flag cleared", fault_n, 1);

    // R11: fault active across strobe
    oc_det = 8'h20;
    tick(SETTLE);
    strobe();
    check("R11 channel 6 off through strobe", drive, 8'hDF);
    check("R11 flag low through strobe", fault_n, 0);
    oc_det = '0;
    tick(SETTLE);
    check("R11 still off after release", drive, 8'hDF);
    strobe();
    check("R7 channel 6 restored", drive, 8'hFF);

    // R9: thermal does not touch flag, and latched channel stays latched
    oc_det = 8'h01;
    tick(SETTLE);
    oc_det = '0;
    ot_det = 1'b1;
    tick(SETTLE);
    check("R9 thermal all off", drive, 8'h00);
    check("R9 flag unaffected", fault_n, 0);
    ot_det = 1'b0;
    tick(SETTLE);
    check("R7 latched survives thermal", drive, 8'hFE);

    // R10: mid-run reset clears register and buffer
    rst_n = 1'b0;
    tick(2);
    check("R10 drive cleared", drive, 0);
    check("R10 flag released", fault_n, 1);
    check("R10 sdo cleared", ser_dout, 0);
    rst_n = 1'b1;
    tick(SETTLE);
    strobe();
    check("R10 register empty after reset", drive, 0);

    done = 1'b1;
    finish_run();
  end

endmodule